// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block returns the devices on a downstream two-wire bus to a known idle state before a new upstream master is connected to that bus. A slave that lost its master part way through a transfer may still be holding SDA low while it waits for clocks. On a start pulse the sequencer clocks the bus nine times with SDA released, so such a slave can shift out its remaining bits. It then gives one more clock with SDA still released, which is a not-acknowledge, and closes with a STOP condition. The block only ever pulls the lines low: its two outputs are pull-low enables for open-drain pads. A released line is pulled high by the bus pull-up resistor.

The `done_o` pulse tells the surrounding selector that it may now connect the newly chosen master and raise that master's completion interrupt. Recovery is optional. When `seq_en_i` is low, a start request bypasses the pattern and `done_o` pulses on the next cycle, so the switch proceeds at once. The SCL half-period is derived at elaboration from the system clock frequency and the target SCL rate. It is rounded up, so the generated clock never runs faster than the target rate. Slave clock stretching and stuck-line detection are not part of this block.

All pins are plain control and status signals. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_recover_seq`

## Requirements
- R1: While reset is asserted, and at all times while `busy_o` is low, `scl_pull_o` and `sda_pull_o` are 0 (both lines released). Reset acts immediately, even in the middle of a sequence, and also clears `busy_o` and `done_o`.
- R2: When `start_i` is sampled high in idle with `seq_en_i` high, `busy_o` rises on that edge. The block then produces RECOVERY_CLOCKS+1 (default 10) SCL pulses. Each pulse is one low phase (`scl_pull_o`=1) followed by one high phase (`scl_pull_o`=0), and each phase lasts exactly HALF system clocks.
- R3: `sda_pull_o` stays 0 through all nine recovery clocks and through the final not-acknowledge clock.
- R4: The STOP condition follows the last high phase and has three steps, each lasting HALF cycles. First both lines are pulled low. Then SCL is released while SDA is still held low. Then both lines are released. `sda_pull_o` never rises while `scl_pull_o` is 0.
- R5: `done_o` is a single-cycle pulse, issued on the same edge on which `busy_o` falls. A full sequence keeps `busy_o` high for (2*(RECOVERY_CLOCKS+1)+3)*HALF cycles.
- R6: When `start_i` is sampled high in idle with `seq_en_i` low, `done_o` pulses on the next cycle. In that case `busy_o` stays 0 and neither line is pulled.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The running sequence keeps its timing and produces exactly one `done_o` pulse.
- R8: HALF = ceil(SYS_CLK_HZ / (2*SCL_HZ)), so the SCL rate never exceeds SCL_HZ. With the defaults of 50 MHz and 400 kHz, HALF is 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a recovery (or a bypassed switch) |
| seq_en_i | input | 1 | 1: run the pattern; 0: complete at once |
| scl_pull_o | output | 1 | 1 pulls downstream SCL low; 0 releases it |
| sda_pull_o | output | 1 | 1 pulls downstream SDA low; 0 releases it |
| busy_o | output | 1 | Pattern in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the following about the inputs:
- `start_i` and `seq_en_i` change only away from the active clock edge, so each is sampled once per edge.
- `seq_en_i` is stable on the edge where a start request is taken.
- Reset may arrive at any moment.

The stimulus follows these rules. It drives inputs one time step after a rising edge. It holds `seq_en_i` steady around every start pulse. It asserts reset both in idle and in the middle of a pattern, so the immediate release of both lines is exercised. It also issues an extra start request in the middle of a sequence, which the design must ignore.

// File: rtl/bus_recover_pkg.sv
package bus_recover_pkg;

  // Phase encoding: bit0 = SCL pull, bit1 = SDA pull, bit2 = busy, bit3 = tag.
  // The outputs are taken straight from the state flops.
  typedef enum logic [3:0] {
    PH_IDLE    = 4'b0000,
    PH_CLK_LO  = 4'b0101,
    PH_CLK_HI  = 4'b0100,
    PH_STOP_LO = 4'b0111,
    PH_STOP_HI = 4'b0110,
    PH_FREE    = 4'b1100
  } phase_e;

  function automatic int half_cycles(input longint sys_hz, input longint scl_hz);
    return int'((sys_hz + 2 * scl_hz - 1) / (2 * scl_hz));
  endfunction

endpackage

// File: rtl/brs_half_timer.sv
module brs_half_timer #(
  parameter int HALF = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/brs_seq_fsm.sv
module brs_seq_fsm
  import bus_recover_pkg::*;
#(
  parameter int CLOCKS = 10
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   en_i,
  input  logic   tick_i,
  output phase_e phase_o,
  output logic   done_o
);
  localparam int BW = $clog2(CLOCKS + 1);
  localparam logic [BW-1:0] LAST_CLK = BW'(CLOCKS - 1);

  phase_e        phase_q;
  logic [BW-1:0] nclk_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      nclk_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            if (en_i) begin
              phase_q <= PH_CLK_LO;
              nclk_q  <= '0;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        PH_CLK_LO:  if (tick_i) phase_q <= PH_CLK_HI;
        PH_CLK_HI: begin
          if (tick_i) begin
            if (nclk_q == LAST_CLK) begin
              phase_q <= PH_STOP_LO;
            end else begin
              nclk_q  <= nclk_q + 1'b1;
              phase_q <= PH_CLK_LO;
            end
          end
        end
        PH_STOP_LO: if (tick_i) phase_q <= PH_STOP_HI;
        PH_STOP_HI: if (tick_i) phase_q <= PH_FREE;
        PH_FREE: begin
          if (tick_i) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;
endmodule

// File: rtl/brs_line_map.sv
module brs_line_map
  import bus_recover_pkg::*;
(
  input  phase_e phase_i,
  output logic   scl_pull_o,
  output logic   sda_pull_o,
  output logic   busy_o
);
  logic [3:0] bits;

  assign bits       = phase_i;
  assign scl_pull_o = bits[0];
  assign sda_pull_o = bits[1];
  assign busy_o     = bits[2];
endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq
  import bus_recover_pkg::*;
#(
  parameter longint SYS_CLK_HZ      = 50_000_000,
  parameter longint SCL_HZ          = 400_000,
  parameter int     RECOVERY_CLOCKS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic seq_en_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o
);
  localparam int HALF   = half_cycles(SYS_CLK_HZ, SCL_HZ);
  localparam int CLOCKS = RECOVERY_CLOCKS + 1;

  phase_e phase;
  logic   tick;
  logic   busy_w;

  brs_half_timer #(.HALF(HALF)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy_w),
    .tick_o (tick)
  );

  brs_seq_fsm #(.CLOCKS(CLOCKS)) fsm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .en_i    (seq_en_i),
    .tick_i  (tick),
    .phase_o (phase),
    .done_o  (done_o)
  );

  brs_line_map map_i (
    .phase_i    (phase),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .busy_o     (busy_w)
  );

  assign busy_o = busy_w;
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
  parameter int HALF = 63
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic seq_en_i,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic busy_o,
  input logic done_o
);
  logic        scl_q;
  logic        busy_q;
  logic [31:0] seg_q;

  // Length of the current SCL level, counted in cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b0;
      busy_q <= 1'b0;
      seg_q  <= '0;
    end else begin
      scl_q  <= scl_pull_o;
      busy_q <= busy_o;
      seg_q  <= (scl_pull_o != scl_q) ? 32'd1 : seg_q + 32'd1;
    end
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_pull_o && !sda_pull_o));

  assert_phase_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_o != scl_q) && busy_o && busy_q |-> seg_q == 32'(HALF));

  assert_no_start_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> scl_pull_o);

  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_bypass_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !$past(busy_o) |-> $past(start_i) && !$past(seq_en_i));
endmodule

bind bus_recover_seq brs_checker #(.HALF(HALF)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .seq_en_i   (seq_en_i),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/bus_recover_seq_tb_top.sv
module bus_recover_seq_tb_top;
  localparam int HALF_T   = (50_000_000 + 2 * 400_000 - 1) / (2 * 400_000);
  localparam int NCLK     = 10;

  typedef struct {
    logic [3:0] vec;   // {scl_pull, sda_pull, busy, done}
    int         len;   // 0 = any length
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic seq_en_i = 1'b1;
  logic scl_pull_o, sda_pull_o, busy_o, done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  bus_recover_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .seq_en_i(seq_en_i),
    .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic void check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endfunction

  task automatic push(input logic [3:0] v, input int n, input string t);
    item_t it;
    it.vec = v; it.len = n; it.tag = t;
    exp_q.push_back(it);
  endtask

  task automatic expect_run(input bit en);
    if (en) begin
      for (int i = 0; i < NCLK; i++) begin
        push(4'b1010, HALF_T, "R2 R3 R8 scl low");
        push(4'b0010, HALF_T, "R2 R3 R8 scl high");
      end
      push(4'b1110, HALF_T, "R4 stop both low");
      push(4'b0110, HALF_T, "R4 stop scl released");
      push(4'b0010, HALF_T, "R4 bus free");
      push(4'b0001, 1, "R5 done pulse with busy low");
    end else begin
      push(4'b0001, 1, "R6 bypass done");
    end
    push(4'b0000, 0, "R1 idle released");
  endtask

  // Monitor: compresses output samples into segments and scores them.
  logic [3:0] prev_v = 4'b0000;
  int seg_len = 0;
  always @(negedge clk) begin
    logic [3:0] cur;
    cur = {scl_pull_o, sda_pull_o, busy_o, done_o};
    if (!rst_n) begin
      prev_v = cur;
      seg_len = 1;
    end else if (cur == prev_v) begin
      seg_len++;
    end else begin
      if (exp_q.size() == 0) begin
        check(0, "unexpected segment", int'(prev_v), -1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(it.vec == prev_v, {it.tag, " level"}, int'(prev_v), int'(it.vec));
        if (it.len != 0)
          check(it.len == seg_len, {it.tag, " length"}, seg_len, it.len);
      end
      prev_v = cur;
      seg_len = 1;
    end
  end

  task automatic pulse_start(input bit en);
    @(posedge clk); #1;
    seq_en_i = en;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
    repeat (5) @(negedge clk);
  endtask

  task automatic apply_reset(input string tag);
    @(posedge clk); #1;
    rst_n = 1'b0;
    exp_q.delete();
    push(4'b0000, 0, "R1 idle after reset");
    #1;
    check({scl_pull_o, sda_pull_o, busy_o, done_o} == 4'b0000, tag,
          int'({scl_pull_o, sda_pull_o, busy_o, done_o}), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    push(4'b0000, 0, "R1 idle after reset");
    #5;
    check({scl_pull_o, sda_pull_o, busy_o, done_o} == 4'b0000, "R1 outputs in reset",
          int'({scl_pull_o, sda_pull_o, busy_o, done_o}), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2 R3 R4 R5: full recovery pattern
    expect_run(1);
    pulse_start(1);
    wait_done();

    // R6: bypass completes at once
    expect_run(0);
    pulse_start(0);
    repeat (6) @(posedge clk);

    // R7: extra start during a running sequence is ignored
    expect_run(1);
    pulse_start(1);
    repeat (300) @(posedge clk);
    #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    wait_done();
    check(exp_q.size() == 1, "R7 one sequence only", exp_q.size(), 1);
    check(busy_o == 1'b0, "R7 idle after ignored start", busy_o, 0);

    // R1: reset in the middle of the pattern releases the lines at once
    expect_run(1);
    pulse_start(1);
    repeat (500) @(posedge clk);
    apply_reset("R1 mid-run reset releases lines");
    repeat (10) @(posedge clk);
    check(busy_o == 1'b0, "R1 busy stays low after reset", busy_o, 0);

    // Second bypass, then a full run after reset
    expect_run(0);
    pulse_start(0);
    repeat (4) @(posedge clk);
    expect_run(1);
    pulse_start(1);
    wait_done();

    check(exp_q.size() == 1, "R5 all segments seen", exp_q.size(), 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule